// File: doc/BRIEF.md
# Four-Phase FM Envelope Generator

This block produces the attenuation envelope of one FM operator. It holds a 12-bit attenuation value, where a larger value means a quieter output and 0xFFC is full silence. It also holds one of four envelope phases. Key-on and key-off strobes move the operator between sounding and fading. A global envelope tick strobe advances the envelope.

On each tick the block works in four steps. It takes the rate field of the current phase and scales it by the channel keycode to get a 6-bit effective rate. It uses a free-running tick counter and a power-of-two prescaler chosen by that rate to decide whether this tick updates the envelope. It then reads an increment from an 8-slot step pattern. Finally it applies the increment:

- In attack, the increment is applied as an exponential approach toward zero attenuation.
- In the other phases, it is added linearly.

The block also gives a one-cycle phase-restart pulse, so the operator's phase accumulator can be cleared on key-on.

States and transitions:

| State | Code | Entered by | Left by |
|---|---|---|---|
| ATTACK | 0 | KEY_ON from any state | ATTACK_DONE (reaches total level) or ATTACK_SKIP (effective rate 63) |
| DECAY | 1 | ATTACK_DONE, or ATTACK_SKIP when the decay rate is not 63 | DECAY_DONE (reaches sustain level) or DECAY_SKIP (effective rate 63); ATTACK_SKIP leads straight here to SUSTAIN when the decay rate is also 63 |
| SUSTAIN | 2 | DECAY_DONE or DECAY_SKIP | KEY_ON or KEY_OFF only |
| RELEASE | 3 | Reset, or KEY_OFF from any state | KEY_ON only |

Top module: `fmeg_env`

## Requirements
- R1: After reset the envelope output is 0xFFC, the phase output is RELEASE (code 3), and the phase-restart pulse is low.
- R2: A `key_on` high on a clock edge sets the envelope to 0xFFC and the phase to ATTACK (code 0), and drives `phase_rst` high for exactly the following cycle. `key_on` wins over `key_off` on the same edge. Key events act whether or not `tick` is high.
- R3: A `key_off` without `key_on` moves the phase to RELEASE (code 3) and leaves the envelope value unchanged.
- R4: The effective rate is 0 when the base rate is 0. Otherwise it is 2·base + (keycode >> (3 − ks_sel)), saturated at 63. The base is the 5-bit attack, decay or sustain field, or 2·rel_rate + 1 in RELEASE.
- R5: A tick counter, cleared by reset, advances on every tick. For an effective rate below 48, an update happens only when the low (47 − rate) >> 2 counter bits are all zero. At 48 and above, every tick updates. With neither tick nor key event, the envelope and phase hold.
- R6: The increment is 4 × step, where step is picked by slot = (counter >> shift) & 7. The rules for step are:
  - For rates 0 to 2, step is 0.
  - For rates 3 to 47, pattern row rate mod 4 is used. The rows are {0,1,0,1,0,1,0,1}, {0,1,0,1,1,1,0,1}, {0,1,1,1,0,1,1,1} and {0,1,1,1,1,1,1,1}, indexed by slot.
  - For rates 48 to 59, upper row rate mod 4 is used, shifted left by rate/4 − 12. The upper rows are {1,1,1,1,1,1,1,1}, {1,1,1,2,1,1,1,2}, {1,2,1,2,1,2,1,2} and {1,2,2,2,1,2,2,2}.
  - For rates 60 to 63, step is 8.
- R7: On an ATTACK update, the envelope drops by ceil((env + 1) · inc / 16). If the result would be at or below the total level (including below zero), the envelope becomes the total level and the phase becomes DECAY.
- R8: On a DECAY, SUSTAIN or RELEASE update, the envelope adds the increment and saturates at 0xFFC. In DECAY, reaching or passing the sustain level sets the envelope to the sustain level and the phase to SUSTAIN.
- R9: On a tick in ATTACK with effective attack rate 63, no increment is applied. The phase goes to SUSTAIN with the envelope at the sustain level if the effective decay rate is also 63. Otherwise it goes to DECAY with the envelope at the total level. In DECAY at effective rate 63, a tick moves straight to SUSTAIN at the sustain level.
- R10: The total level is the 7-bit `tl_field` shifted left by 5. The sustain level is the 4-bit `sl_field` shifted left by 8.
- R11: SUSTAIN and RELEASE never change phase on a tick; only key events leave them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Global envelope tick strobe |
| key_on | input | 1 | Key-on strobe |
| key_off | input | 1 | Key-off strobe |
| atk_rate | input | 5 | Attack rate field |
| dec_rate | input | 5 | Decay rate field |
| sus_rate | input | 5 | Sustain rate field |
| rel_rate | input | 4 | Release rate field |
| tl_field | input | 7 | Total level field |
| sl_field | input | 4 | Sustain level field |
| ks_sel | input | 2 | Key-scaling selector |
| keycode | input | 5 | Channel keycode |
| env_out | output | 12 | Attenuation envelope |
| phase_out | output | 2 | Current phase code |
| phase_rst | output | 1 | One-cycle phase-accumulator restart pulse |

## Verification
Mid-range rates with no key scaling trace a full attack-decay-sustain-release cycle. This separates the exponential attack from the linear phases and shows the sustain-level handoff. The same attack rate under different keycodes and `ks_sel` values shows whether key scaling enters the rate and moves the prescaler. Zero rates, near-top rates (60 to 62) and rate-63 settings tell apart three cases: no movement, a one-update clamp to the total level, and the tick-only skip through attack and decay. Tickless stretches and coincident key strobes separate hold behaviour from key priority.

// File: rtl/fmeg_pkg.sv
package fmeg_pkg;

    localparam int ENV_W     = 12;
    localparam int RATE_W    = 6;
    localparam int FIELD_W   = 5;
    localparam int KC_W      = 5;
    localparam int INC_W     = 6;
    localparam logic [ENV_W-1:0]  ENV_MAX  = 12'hFFC;
    localparam logic [RATE_W-1:0] RATE_TOP = 6'd63;

    typedef enum logic [1:0] {
        EG_ATTACK  = 2'd0,
        EG_DECAY   = 2'd1,
        EG_SUSTAIN = 2'd2,
        EG_RELEASE = 2'd3
    } eg_phase_t;

    // Step value (before the x4 scaling) for an effective rate and slot.
    function automatic logic [3:0] step_lookup(input logic [RATE_W-1:0] rate,
                                               input logic [2:0] slot);
        logic [7:0] base_pat;
        logic [7:0] extra_pat;
        logic [3:0] val;
        unique case (rate[1:0])
            2'd0: begin base_pat = 8'hAA; extra_pat = 8'h00; end
            2'd1: begin base_pat = 8'hBA; extra_pat = 8'h88; end
            2'd2: begin base_pat = 8'hEE; extra_pat = 8'hAA; end
            2'd3: begin base_pat = 8'hFE; extra_pat = 8'hEE; end
        endcase
        if (rate < 6'd3)
            val = 4'd0;
        else if (rate >= 6'd60)
            val = 4'd8;
        else if (rate < 6'd48)
            val = {3'b000, base_pat[slot]};
        else
            val = (4'd1 + {3'b000, extra_pat[slot]}) << (rate[5:2] - 4'd12);
        return val;
    endfunction

endpackage

// File: rtl/fmeg_rate.sv
module fmeg_rate
    import fmeg_pkg::*;
(
    input  logic [FIELD_W-1:0] base,
    input  logic [KC_W-1:0]    keycode,
    input  logic [1:0]         ks_sel,
    output logic [RATE_W-1:0]  eff
);

    localparam int SUM_W = RATE_W + 1;

    logic [KC_W-1:0]  ks_add;
    logic [SUM_W-1:0] sum;

    always_comb begin
        ks_add = keycode >> (2'd3 - ks_sel);
        sum    = SUM_W'({base, 1'b0}) + SUM_W'(ks_add);
        if (base == '0)
            eff = '0;
        else if (sum > SUM_W'(RATE_TOP))
            eff = RATE_TOP;
        else
            eff = sum[RATE_W-1:0];
    end

endmodule

// File: rtl/fmeg_gate.sv
module fmeg_gate
    import fmeg_pkg::*;
#(
    parameter int TICK_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic [RATE_W-1:0] eff,
    output logic              upd,
    output logic [INC_W-1:0]  inc
);

    logic [TICK_W-1:0] cnt_q;
    logic [TICK_W-1:0] mask;
    logic [TICK_W-1:0] shifted;
    logic [3:0]        shift;

    always_comb begin
        shift   = (eff < 6'd48) ? 4'((6'd47 - eff) >> 2) : 4'd0;
        mask    = (TICK_W'(1) << shift) - TICK_W'(1);
        shifted = cnt_q >> shift;
        upd     = tick && ((cnt_q & mask) == '0);
        inc     = {step_lookup(eff, shifted[2:0]), 2'b00};
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + TICK_W'(1);
    end

    // R6: the slowest rates never produce an increment
    p_slow_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (upd && eff < 6'd3) |-> inc == '0);

endmodule

// File: rtl/fmeg_env.sv
module fmeg_env
    import fmeg_pkg::*;
#(
    parameter int TICK_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tick,
    input  logic               key_on,
    input  logic               key_off,
    input  logic [FIELD_W-1:0] atk_rate,
    input  logic [FIELD_W-1:0] dec_rate,
    input  logic [FIELD_W-1:0] sus_rate,
    input  logic [3:0]         rel_rate,
    input  logic [6:0]         tl_field,
    input  logic [3:0]         sl_field,
    input  logic [1:0]         ks_sel,
    input  logic [KC_W-1:0]    keycode,
    output logic [ENV_W-1:0]   env_out,
    output logic [1:0]         phase_out,
    output logic               phase_rst
);

    localparam int ADD_W  = ENV_W + 1;
    localparam int PROD_W = ENV_W + INC_W + 1;
    localparam int SUB_W  = ENV_W + 3;

    eg_phase_t           ph_q, ph_d;
    logic [ENV_W-1:0]    env_q, env_d;
    logic                prst_q;

    logic [ENV_W-1:0]    tl_lvl, sl_lvl;
    logic [FIELD_W-1:0]  base_cur;
    logic [RATE_W-1:0]   eff_cur, eff_dec;
    logic                upd;
    logic [INC_W-1:0]    inc;

    logic [PROD_W-1:0]   atk_prod;
    logic [SUB_W-1:0]    atk_sub;
    logic                atk_hit;
    logic [ENV_W-1:0]    atk_val;
    logic [ADD_W-1:0]    add_sum;
    logic [ENV_W-1:0]    add_sat;

    assign tl_lvl = {tl_field, 5'b0};
    assign sl_lvl = {sl_field, 8'b0};

    always_comb begin
        unique case (ph_q)
            EG_ATTACK:  base_cur = atk_rate;
            EG_DECAY:   base_cur = dec_rate;
            EG_SUSTAIN: base_cur = sus_rate;
            EG_RELEASE: base_cur = {rel_rate, 1'b1};
        endcase
    end

    fmeg_rate u_rate_cur (
        .base    (base_cur),
        .keycode (keycode),
        .ks_sel  (ks_sel),
        .eff     (eff_cur)
    );

    fmeg_rate u_rate_dec (
        .base    (dec_rate),
        .keycode (keycode),
        .ks_sel  (ks_sel),
        .eff     (eff_dec)
    );

    fmeg_gate #(.TICK_W(TICK_W)) u_gate (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .eff   (eff_cur),
        .upd   (upd),
        .inc   (inc)
    );

    // Exponential attack step and linear saturating step
    always_comb begin
        atk_prod = PROD_W'(ADD_W'(env_q) + ADD_W'(1)) * PROD_W'(inc);
        atk_sub  = SUB_W'((atk_prod + PROD_W'(15)) >> 4);
        atk_hit  = SUB_W'(env_q) <= (SUB_W'(tl_lvl) + atk_sub);
        atk_val  = env_q - atk_sub[ENV_W-1:0];
        add_sum  = ADD_W'(env_q) + ADD_W'(inc);
        add_sat  = (add_sum > ADD_W'(ENV_MAX)) ? ENV_MAX : add_sum[ENV_W-1:0];
    end

    // Next-state logic
    always_comb begin
        ph_d  = ph_q;
        env_d = env_q;
        if (key_on) begin
            ph_d  = EG_ATTACK;
            env_d = ENV_MAX;
        end else if (key_off) begin
            ph_d  = EG_RELEASE;
        end else if (tick) begin
            unique case (ph_q)
                EG_ATTACK: begin
                    if (eff_cur == RATE_TOP) begin
                        if (eff_dec == RATE_TOP) begin
                            ph_d  = EG_SUSTAIN;
                            env_d = sl_lvl;
                        end else begin
                            ph_d  = EG_DECAY;
                            env_d = tl_lvl;
                        end
                    end else if (upd) begin
                        if (atk_hit) begin
                            ph_d  = EG_DECAY;
                            env_d = tl_lvl;
                        end else begin
                            env_d = atk_val;
                        end
                    end
                end
                EG_DECAY: begin
                    if (eff_cur == RATE_TOP) begin
                        ph_d  = EG_SUSTAIN;
                        env_d = sl_lvl;
                    end else if (upd) begin
                        if (add_sat >= sl_lvl) begin
                            ph_d  = EG_SUSTAIN;
                            env_d = sl_lvl;
                        end else begin
                            env_d = add_sat;
                        end
                    end
                end
                EG_SUSTAIN, EG_RELEASE: begin
                    if (upd)
                        env_d = add_sat;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph_q  <= EG_RELEASE;
            env_q <= ENV_MAX;
        end else begin
            ph_q  <= ph_d;
            env_q <= env_d;
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n)
            prst_q <= 1'b0;
        else
            prst_q <= key_on;
    end

    assign env_out   = env_q;
    assign phase_out = ph_q;
    assign phase_rst = prst_q;

    // R8: attenuation never exceeds the ceiling
    p_env_ceiling_r8: assert property (@(posedge clk) disable iff (!rst_n)
        env_q <= ENV_MAX);

    // R2: key-on restarts the envelope and pulses the phase restart
    p_key_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        key_on |=> (ph_q == EG_ATTACK && env_q == ENV_MAX && phase_rst));

    // R3: key-off enters release without touching the level
    p_key_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (key_off && !key_on) |=> (ph_q == EG_RELEASE && env_q == $past(env_q)));

    // R5: nothing moves without a tick or key event
    p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !key_on && !key_off) |=>
            (env_q == $past(env_q) && ph_q == $past(ph_q)));

    // R7: attack only lowers the attenuation while it stays in attack
    p_attack_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == EG_ATTACK && !key_on && !key_off) |=>
            (ph_q != EG_ATTACK || env_q <= $past(env_q)));

    // R8: sustain is entered from decay exactly at the sustain level
    p_sustain_entry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ph_q == EG_DECAY && !key_on && !key_off) |=>
            (ph_q != EG_SUSTAIN || env_q == $past(sl_lvl)));

    // R1: the restart pulse only follows a key-on
    p_prst_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase_rst |-> $past(key_on));

endmodule

// File: tb/fmeg_env_test.sv
`timescale 1ns/1ps
module fmeg_env_test;

    localparam int TICK_W = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        key_on = 1'b0;
    logic        key_off = 1'b0;
    logic [4:0]  atk_rate = '0;
    logic [4:0]  dec_rate = '0;
    logic [4:0]  sus_rate = '0;
    logic [3:0]  rel_rate = '0;
    logic [6:0]  tl_field = '0;
    logic [3:0]  sl_field = '0;
    logic [1:0]  ks_sel = '0;
    logic [4:0]  keycode = '0;
    logic [11:0] env_out;
    logic [1:0]  phase_out;
    logic        phase_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    int m_env, m_ph, m_cnt;

    int main_tab[4][8] = '{'{0,1,0,1,0,1,0,1}, '{0,1,0,1,1,1,0,1},
                           '{0,1,1,1,0,1,1,1}, '{0,1,1,1,1,1,1,1}};
    int top_tab[4][8]  = '{'{1,1,1,1,1,1,1,1}, '{1,1,1,2,1,1,1,2},
                           '{1,2,1,2,1,2,1,2}, '{1,2,2,2,1,2,2,2}};

    always #2 clk = ~clk;

    fmeg_env #(.TICK_W(TICK_W)) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .key_on(key_on), .key_off(key_off),
        .atk_rate(atk_rate), .dec_rate(dec_rate), .sus_rate(sus_rate),
        .rel_rate(rel_rate), .tl_field(tl_field), .sl_field(sl_field),
        .ks_sel(ks_sel), .keycode(keycode), .env_out(env_out),
        .phase_out(phase_out), .phase_rst(phase_rst)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // R4: effective rate from the requirement
    function automatic int eff_of(input int base);
        int v;
        if (base == 0) return 0;
        v = 2 * base + (int'(keycode) >> (3 - int'(ks_sel)));
        return (v > 63) ? 63 : v;
    endfunction

    // R6: step from the listed pattern rows
    function automatic int step_of(input int r, input int c);
        if (r < 3) return 0;
        if (r >= 60) return 8;
        if (r < 48) return main_tab[r % 4][c];
        return top_tab[r % 4][c] * (1 << (r / 4 - 12));
    endfunction

    task automatic model_tick();
        int base, r, sh, c, inc, sub, s, tl, sl;
        bit upd;
        tl = int'(tl_field) * 32;
        sl = int'(sl_field) * 256;
        case (m_ph)
            0: base = int'(atk_rate);
            1: base = int'(dec_rate);
            2: base = int'(sus_rate);
            default: base = int'(rel_rate) * 2 + 1;
        endcase
        r   = eff_of(base);
        sh  = (r < 48) ? (47 - r) / 4 : 0;
        upd = (m_cnt % (1 << sh)) == 0;
        c   = (m_cnt >> sh) & 7;
        inc = step_of(r, c) * 4;
        m_cnt = (m_cnt + 1) % (1 << TICK_W);
        if (m_ph == 0) begin
            if (r == 63) begin
                if (eff_of(int'(dec_rate)) == 63) begin m_ph = 2; m_env = sl; end
                else begin m_ph = 1; m_env = tl; end
            end else if (upd) begin
                sub = ((m_env + 1) * inc + 15) / 16;
                if (m_env - sub <= tl) begin m_env = tl; m_ph = 1; end
                else m_env = m_env - sub;
            end
        end else if (m_ph == 1) begin
            if (r == 63) begin m_ph = 2; m_env = sl; end
            else if (upd) begin
                s = m_env + inc;
                if (s > 4092) s = 4092;
                if (s >= sl) begin m_env = sl; m_ph = 2; end
                else m_env = s;
            end
        end else if (upd) begin
            s = m_env + inc;
            m_env = (s > 4092) ? 4092 : s;
        end
    endtask

    task automatic compare_state(input string tag);
        check(int'(env_out) == m_env && int'(phase_out) == m_ph, tag,
              {int'(phase_out), 16'(env_out)}, {m_ph, 16'(m_env)});
    endtask

    task automatic run_ticks(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(posedge clk);
            model_tick();
            @(negedge clk);
            compare_state(tag);
            check(phase_rst == 1'b0, {tag, " restart pulse idle"}, int'(phase_rst), 0);
        end
        tick = 1'b0;
    endtask

    task automatic run_to_phase(input int ph, input int max_n, input string tag);
        for (int i = 0; i < max_n && m_ph != ph; i++) run_ticks(1, tag);
        check(m_ph == ph && int'(phase_out) == ph, {tag, " phase reached"}, int'(phase_out), ph);
    endtask

    task automatic key_evt(input bit on, input bit off, input string tag);
        key_on = on;
        key_off = off;
        @(posedge clk);
        if (on) begin m_ph = 0; m_env = 4092; end
        else if (off) m_ph = 3;
        @(negedge clk);
        key_on = 1'b0;
        key_off = 1'b0;
        compare_state(tag);
        check(phase_rst == on, {tag, " restart pulse"}, int'(phase_rst), int'(on));
    endtask

    task automatic t_reset();
        check(env_out == 12'hFFC, "R1 reset envelope", int'(env_out), 'hFFC);
        check(phase_out == 2'd3, "R1 reset phase", int'(phase_out), 3);
        check(phase_rst == 1'b0, "R1 reset pulse", int'(phase_rst), 0);
    endtask

    task automatic t_zero_rate();
        atk_rate = 5'd0; ks_sel = 2'd3; keycode = 5'd31;
        key_evt(1, 0, "R2 key-on");
        @(negedge clk);
        check(phase_rst == 1'b0, "R2 pulse one cycle", int'(phase_rst), 0);
        run_ticks(300, "R4 zero attack rate holds");
        check(env_out == 12'hFFC && phase_out == 2'd0, "R6 zero rate no step",
              int'(env_out), 'hFFC);
    endtask

    task automatic t_adsr();
        atk_rate = 5'd20; dec_rate = 5'd18; sus_rate = 5'd10; rel_rate = 4'd8;
        tl_field = 7'h20; sl_field = 4'd6; ks_sel = 2'd0; keycode = 5'h1F;
        key_evt(1, 0, "R2 key-on adsr");
        run_to_phase(1, 4000, "R7 attack to decay");
        check(int'(env_out) == 'h400, "R10 total level on decay entry", int'(env_out), 'h400);
        run_to_phase(2, 8000, "R8 decay to sustain");
        check(int'(env_out) == 'h600, "R10 sustain level on entry", int'(env_out), 'h600);
        run_ticks(1000, "R11 sustain holds phase");
        key_evt(0, 1, "R3 key-off");
        run_ticks(6000, "R8 release slope");
        check(env_out == 12'hFFC && phase_out == 2'd3, "R8 release saturates",
              int'(env_out), 'hFFC);
    endtask

    task automatic t_fast();
        atk_rate = 5'd31; dec_rate = 5'd31; sus_rate = 5'd31;
        ks_sel = 2'd3; keycode = 5'd31; tl_field = 7'h10; sl_field = 4'd5;
        key_evt(1, 0, "R2 key-on fast");
        run_ticks(1, "R9 double skip");
        check(phase_out == 2'd2 && env_out == 12'h500, "R9 skip to sustain",
              int'(env_out), 'h500);
        run_ticks(200, "R8 top rate sustain");
        check(env_out == 12'hFFC && phase_out == 2'd2, "R11 sustain saturates in place",
              int'(env_out), 'hFFC);
        dec_rate = 5'd10;
        key_evt(1, 0, "R2 key-on skip one");
        run_ticks(1, "R9 single skip");
        check(phase_out == 2'd1 && env_out == 12'h200, "R9 skip to decay",
              int'(env_out), 'h200);
        run_ticks(400, "R8 decay after skip");
        atk_rate = 5'd30; ks_sel = 2'd0; keycode = 5'h10;
        key_evt(1, 0, "R2 key-on rate 62");
        run_ticks(1, "R7 near-top attack");
        check(phase_out == 2'd1 && env_out == 12'h200, "R7 clamp to total level",
              int'(env_out), 'h200);
    endtask

    task automatic t_keyscale();
        atk_rate = 5'd12; dec_rate = 5'd14; tl_field = 7'h08; sl_field = 4'd9;
        for (int k = 0; k < 4; k++) begin
            ks_sel = 2'(k);
            keycode = 5'(7 * k + 3);
            key_evt(1, 0, "R4 key-on scaled");
            run_ticks(700, "R4 key-scaled rates");
        end
    endtask

    task automatic t_misc();
        key_evt(1, 1, "R2 key-on wins over key-off");
        run_ticks(5, "R5 after priority");
        for (int i = 0; i < 50; i++) @(negedge clk);
        compare_state("R5 no tick holds state");
        key_evt(0, 1, "R3 key-off mid attack");
        run_ticks(100, "R11 release continues");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        m_env = 4092; m_ph = 3; m_cnt = 0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_zero_rate();
        t_adsr();
        t_fast();
        t_keyscale();
        t_misc();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule